// File: doc/BRIEF.md
# Vertical Flush Pulse Generator with Line-Spanning Sweep

This block produces a repetitive vertical clock pulse train used to clear residual charge out of an image sensor's vertical shift registers before readout. One pulse period is described by three positions measured in pixel clocks from the start of the period. The output rises at the first, falls at the second, and the period ends after the third, where the next repeat begins. A repeat count sets how many periods are produced.

A train is started by a one-cycle `start` strobe, which also captures the repeat count and the sweep setting of the active region. In the normal mode a horizontal line strobe ends the train at once, so the train never runs past a line boundary. Each of the regions has its own sweep-enable bit. When the bit of the region active at start is set, line strobes are ignored and the train runs through every repeat, across as many lines as it needs. A `done` level reports that the train has ended. The surrounding sequencer then moves to its next region, where normal operation applies again.

Top module: `vps_sweep_gen`

## Requirements
- R1: During reset and after its release, before any start, `vout` and `done` are low.
- R2: Count cycles from the clock edge that samples `start` as offset 0, with period P = third + 1. While the train is active, `vout` is high at offset t exactly when (t mod P) >= first and (t mod P) < second. Positions assume first <= second <= third + 1.
- R3: With a repeat count N > 0 and no truncation, `done` is low for offsets 0 to N*P-1. From offset N*P `done` is high and `vout` is low, and both stay so until the next start.
- R4: A repeat count of 0 produces no pulse, and `done` is high from offset 0.
- R5: In a train started without sweep, a line strobe sampled at offset T >= 1 ends the train. From offset T `vout` is low and `done` is high. A strobe sampled together with `start` has no effect.
- R6: When bit k of `sweep_en` is 1 and `region_idx` equals k at start, line strobes do not affect the train, and a repeat count of up to 4096 completes fully as in R3.
- R7: A `region_idx` value of 5 or more at start selects no sweep, whatever `sweep_en` holds, so such a train is truncated as in R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle strobe that begins a train and captures settings |
| hd_strobe | input | 1 | One-cycle horizontal line boundary strobe |
| region_idx | input | 3 | Index of the active vertical region |
| sweep_en | input | 5 | Sweep-enable bit for each region |
| tog_first | input | 12 | Offset in the period where the output rises |
| tog_second | input | 12 | Offset in the period where the output falls |
| tog_third | input | 12 | Last offset of the period |
| rep_count | input | 13 | Number of pulse periods, 0 to 4096 |
| vout | output | 1 | Vertical pulse train |
| done | output | 1 | High once the train has ended, cleared by start |

## Verification
Every result follows the edge that samples its cause by exactly one register stage. The first period's phase 0 appears right after the start edge, completion appears after edge N*(third+1), and truncation appears after the edge that samples the line strobe. The bench starts its offset count at the start edge and compares both outputs at each falling edge against the offset arithmetic of R2 to R7. It drives the line strobe so that its sampling edge falls at a chosen offset. That way every expected transition lands on a known sample. Small position sets are swept exhaustively, with repeat counts 0 to 3, in four region and strobe modes. Two long trains of 4096 repeats, one with sweep and one without, run under a periodic line strobe.

// File: rtl/vps_pkg.sv
`timescale 1ns/1ps
// Package: shared defaults and the run-state type of the vertical flush
// pulse generator. Assumes all widths are positive.
package vps_pkg;
    parameter int unsigned VPS_POS_W = 12;  // pixel position width
    parameter int unsigned VPS_REP_W = 13;  // repeat count width (0..4096)
    parameter int unsigned VPS_NREG  = 5;   // number of vertical regions

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;
endpackage

// File: rtl/vps_phase_ctr.sv
`timescale 1ns/1ps
// Module: in-period phase counter and pulse shaper.
// Counts pixel clocks within one pulse period while the train runs, wraps
// after the third position and forms the output level from the first and
// second positions. Assumes first <= second <= third + 1.
module vps_phase_ctr #(
    parameter int unsigned POS_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic [POS_W-1:0] pos_rise,
    input  logic [POS_W-1:0] pos_fall,
    input  logic [POS_W-1:0] pos_end,
    output logic             wrap,
    output logic             level
);
    logic [POS_W-1:0] phase_q;

    // Period end is reached on the last offset of the period.
    assign wrap  = run && (phase_q == pos_end);
    // Output is high inside the rise..fall window of an active period.
    assign level = run && (phase_q >= pos_rise) && (phase_q < pos_fall);

    // Advance the phase, restart it at the period end, hold zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (clr || !run) begin
            phase_q <= '0;
        end else if (wrap) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end
endmodule

// File: rtl/vps_repeat_ctr.sv
`timescale 1ns/1ps
// Module: remaining-repeat counter.
// Loads the repeat count at start, decrements once per completed period
// and flags the final period. Cleared when a train is cut short.
module vps_repeat_ctr #(
    parameter int unsigned REP_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             clr,
    input  logic             step,
    input  logic [REP_W-1:0] count_in,
    output logic             last
);
    logic [REP_W-1:0] remain_q;

    // The final period is in progress when one repeat remains.
    assign last = (remain_q == REP_W'(1));

    // Load, clear or count down the remaining repeats.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (load) begin
            remain_q <= count_in;
        end else if (clr) begin
            remain_q <= '0;
        end else if (step && (remain_q != '0)) begin
            remain_q <= remain_q - 1'b1;
        end
    end
endmodule

// File: rtl/vps_ctrl.sv
`timescale 1ns/1ps
// Module: train controller.
// Starts a train on the start strobe, captures the sweep decision for the
// active region, ends the train on completion or (without sweep) on a line
// strobe, and keeps the done level. Start takes priority over all else.
module vps_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic hd_strobe,
    input  logic sweep_sel,
    input  logic rep_zero,
    input  logic wrap,
    input  logic last,
    output logic run,
    output logic sweep_act,
    output logic stop,
    output logic done
);
    import vps_pkg::*;

    run_state_e state_q;
    logic       sweep_q;
    logic       done_q;

    assign run       = (state_q == ST_RUN);
    assign sweep_act = sweep_q;
    assign done      = done_q;
    // A running train ends after its final period or on an unswept line end.
    assign stop = run && !start &&
                  ((wrap && last) || (hd_strobe && !sweep_q));

    // Track run state, latched sweep decision and done level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sweep_q <= 1'b0;
            done_q  <= 1'b0;
        end else if (start) begin
            state_q <= rep_zero ? ST_IDLE : ST_RUN;
            sweep_q <= sweep_sel;
            done_q  <= rep_zero;
        end else if (stop) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
        end
    end
endmodule

// File: rtl/vps_sweep_gen.sv
`timescale 1ns/1ps
// Module: vertical flush pulse generator with line-spanning sweep (top).
// Selects the sweep bit of the active region, then ties together the
// controller, the phase counter and the repeat counter. Region indices at or
// above NREG select no sweep. All settings except the position inputs are
// captured at start; positions must stay stable while a train runs.
module vps_sweep_gen #(
    parameter int unsigned POS_W = vps_pkg::VPS_POS_W,
    parameter int unsigned REP_W = vps_pkg::VPS_REP_W,
    parameter int unsigned NREG  = vps_pkg::VPS_NREG,
    localparam int unsigned REG_W = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             hd_strobe,
    input  logic [REG_W-1:0] region_idx,
    input  logic [NREG-1:0]  sweep_en,
    input  logic [POS_W-1:0] tog_first,
    input  logic [POS_W-1:0] tog_second,
    input  logic [POS_W-1:0] tog_third,
    input  logic [REP_W-1:0] rep_count,
    output logic             vout,
    output logic             done
);
    logic [NREG-1:0] region_hit;
    logic            sweep_sel;
    logic            run_act;
    logic            sweep_act;
    logic            stop;
    logic            wrap;
    logic            rem_last;
    logic            rep_zero;

    // One decoder line per region; out-of-range indices hit none.
    for (genvar gi = 0; gi < NREG; gi++) begin : g_region
        assign region_hit[gi] = (int'(region_idx) == gi) && sweep_en[gi];
    end

    // Sweep applies if the active region's enable bit is set.
    assign sweep_sel = |region_hit;
    assign rep_zero  = (rep_count == '0);

    vps_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .hd_strobe (hd_strobe),
        .sweep_sel (sweep_sel),
        .rep_zero  (rep_zero),
        .wrap      (wrap),
        .last      (rem_last),
        .run       (run_act),
        .sweep_act (sweep_act),
        .stop      (stop),
        .done      (done)
    );

    vps_phase_ctr #(.POS_W(POS_W)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (start || stop),
        .run      (run_act),
        .pos_rise (tog_first),
        .pos_fall (tog_second),
        .pos_end  (tog_third),
        .wrap     (wrap),
        .level    (vout)
    );

    vps_repeat_ctr #(.REP_W(REP_W)) u_rep (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start),
        .clr      (stop),
        .step     (wrap),
        .count_in (rep_count),
        .last     (rem_last)
    );
endmodule

// File: rtl/vps_sweep_chk.sv
`timescale 1ns/1ps
// Module: assertion checker for vps_sweep_gen, attached by bind.
// Observes ports and the controller's run and sweep state.
module vps_sweep_chk #(
    parameter int unsigned REP_W = 13,
    parameter int unsigned REG_W = 3,
    parameter int unsigned NREG  = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             hd_strobe,
    input logic [REG_W-1:0] region_idx,
    input logic [REP_W-1:0] rep_count,
    input logic             vout,
    input logic             done,
    input logic             run_act,
    input logic             sweep_act,
    input logic             rem_last
);
    // R1: reset leaves both outputs low.
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!vout && !done));

    // R2: the pulse is only present while the train has not ended.
    p_pulse_not_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        vout |-> !done);

    // R3: a nonzero start clears done.
    p_start_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && rep_count != '0) |=> !done);

    // R3: done holds until the next start.
    p_done_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    // R4: zero repeats ends at once with no pulse.
    p_zero_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && rep_count == '0) |=> (done && !vout));

    // R5: an unswept line strobe ends the running train.
    p_truncate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run_act && !start && !sweep_act && hd_strobe) |=> (done && !vout));

    // R6: a swept train survives a line strobe before its final period.
    p_sweep_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run_act && !start && sweep_act && hd_strobe && !rem_last) |=> !done);

    // R7: an out-of-range region never selects sweep.
    p_region_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && int'(region_idx) >= NREG) |=> !sweep_act);
endmodule

bind vps_sweep_gen vps_sweep_chk #(
    .REP_W (REP_W),
    .REG_W (REG_W),
    .NREG  (NREG)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .hd_strobe  (hd_strobe),
    .region_idx (region_idx),
    .rep_count  (rep_count),
    .vout       (vout),
    .done       (done),
    .run_act    (run_act),
    .sweep_act  (sweep_act),
    .rem_last   (rem_last)
);

// File: tb/sim_vps_sweep_gen.sv
`timescale 1ns/1ps
// Bench: exhaustive sweep of small pulse shapes and repeat counts in four
// region/strobe modes, plus long 4096-repeat trains; expectations computed
// from offset arithmetic.
module sim_vps_sweep_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        hd_strobe = 1'b0;
    logic [2:0]  region_idx = '0;
    logic [4:0]  sweep_en = '0;
    logic [11:0] tog_first = '0;
    logic [11:0] tog_second = '0;
    logic [11:0] tog_third = '0;
    logic [12:0] rep_count = '0;
    logic        vout;
    logic        done;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 1'b0;

    always #2 clk = ~clk;

    vps_sweep_gen u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .hd_strobe  (hd_strobe),
        .region_idx (region_idx),
        .sweep_en   (sweep_en),
        .tog_first  (tog_first),
        .tog_second (tog_second),
        .tog_third  (tog_third),
        .rep_count  (rep_count),
        .vout       (vout),
        .done       (done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t",
                     req, what, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // One train: positions a,b,c, count n, region rg, enables en, line
    // strobe sampled at every offset that is a multiple of hp (0 = none).
    task automatic run_train(input int a, input int b, input int c, input int n,
                             input int rg, input logic [4:0] en, input int hp);
        int  p     = c + 1;
        bit  swp   = (rg < 5) && en[rg];
        int  tcut  = (hp > 0 && !swp) ? hp : 32'h3fff_ffff;
        int  endt  = n * p;
        int  lim   = ((endt < tcut) ? endt : tcut) + 3;
        @(negedge clk);
        tog_first  = 12'(a);
        tog_second = 12'(b);
        tog_third  = 12'(c);
        rep_count  = 13'(n);
        region_idx = 3'(rg);
        sweep_en   = en;
        start      = 1'b1;
        hd_strobe  = 1'b0;
        @(negedge clk);
        start = 1'b0;
        for (int t = 0; t <= lim; t++) begin
            bit    act   = (t < endt) && (t < tcut);
            int    ph    = t % p;
            bit    ev    = act && (ph >= a) && (ph < b);
            string rv, rd;
            if (hp > 0 && swp)        rv = "R6";
            else if (t >= tcut)       rv = (rg >= 5) ? "R7" : "R5";
            else                      rv = "R2";
            if (n == 0)               rd = "R4";
            else if (hp > 0 && swp)   rd = "R6";
            else if (t >= tcut)       rd = (rg >= 5) ? "R7" : "R5";
            else                      rd = "R3";
            check(vout === ev, rv, "vout", int'(vout), int'(ev));
            check(done === !act, rd, "done", int'(done), int'(!act));
            hd_strobe = (hp > 0) && (((t + 1) % hp) == 0);
            @(negedge clk);
        end
        hd_strobe = 1'b0;
    endtask

    initial begin
        // R1: outputs quiet in and right after reset.
        repeat (3) @(negedge clk);
        check(vout === 1'b0 && done === 1'b0, "R1", "vout|done in reset",
              int'({vout, done}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(vout === 1'b0 && done === 1'b0, "R1", "vout|done after reset",
              int'({vout, done}), 0);

        // Exhaustive small shapes; modes: plain, strobed, swept, bad region.
        for (int c = 0; c <= 4; c++)
            for (int a = 0; a <= c; a++)
                for (int b = a; b <= c + 1; b++)
                    for (int n = 0; n <= 3; n++)
                        for (int m = 0; m < 4; m++) begin
                            int hp = (n * (c + 1)) / 2 + 1;
                            case (m)
                                0: run_train(a, b, c, n, 0, 5'b00000, 0);
                                1: run_train(a, b, c, n, 2, 5'b11011, hp);
                                2: run_train(a, b, c, n, 4, 5'b10000, hp);
                                default: run_train(a, b, c, n, 5, 5'b11111, hp);
                            endcase
                        end

        // R6: full 4096-repeat sweep across many line strobes.
        run_train(1, 2, 3, 4096, 3, 5'b01000, 50);
        // R5: the same train without sweep stops at the first line strobe.
        run_train(1, 2, 3, 4096, 3, 5'b10111, 50);

        finish_run();
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end
endmodule